// File: doc/BRIEF.md
# Rounded Truncated Array Multiplier

This block multiplies two unsigned N-bit operands and returns only the upper N bits of the 2N-bit product, rounded to nearest. The lowest product columns are never built, which saves area and power. Only columns from index T = N - K upward are formed, where K is the number of guard columns kept below the output. The partial products that would land in column T-1 are not thrown away. Each of them is added one column higher, at weight 2^T, as an estimate of the discarded low part. A single rounding bit of weight 2^(N-1) is also added. The result is the upper half of that corrected sum.

All terms are gathered as rows of an operand matrix and reduced by a linear carry-save array. A carry-propagate adder then resolves the last two vectors. A parameter chooses between a ripple adder and a parallel-prefix adder for this last step. A second parameter selects either a purely combinational output or a single register stage with synchronous reset.

Top module: `trunc_round_mul`

## Requirements
- R1: Let T = N - K. Let S be the sum of three kinds of term: a[c]·b[r]·2^(r+c) for every pair with r+c ≥ T, a[c]·b[r]·2^T for every pair with r+c = T-1, and the constant 2^(N-1). Then prod_hi equals bits [2N-1:N] of S.
- R2: S is always below 2^(2N), so no carry leaves bit 2N-1, even when both operands are all ones.
- R3: With N = 6 and K = 2, prod_hi never differs by more than one unit from floor((a·b + 2^(N-1)) / 2^N), for every pair of operands.
- R4: When either operand is zero, prod_hi is zero.
- R5: With REG_OUT = 1, prod_hi shows the result for the operands present at the previous rising clock edge. When rst is high at a rising edge, prod_hi becomes zero at that edge, whatever the operands are.
- R6: With REG_OUT = 0, prod_hi follows the operands within the same cycle, with no clock edge needed.
- R7: With K = 0 (T = N), the correction comes from column N-1 at weight 2^N, and the rounding bit sits at column N-1. The result still follows the R1 formula exactly.
- R8: ADDER_ARCH = ADD_RIPPLE (0) selects a ripple-carry adder and ADD_PREFIX (1) selects a parallel-prefix adder for the final step. Both give exactly the R1 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod_hi | output | N | Rounded upper half of the corrected product |

## Verification
In the registered variant, a synchronous reset and the capture of a fresh operand pair can fall on the same rising edge. The bench provokes this by driving nonzero operands, including all ones, while rst is high, both at start-up and again in the middle of the exhaustive sweep. It judges that the output is zero after that edge. It also judges that the first pair applied after rst falls comes out exactly one edge later. The bench also sweeps every operand pair through both the column-correction path and the rounding bit. At the all-ones corner these two carry into the top column together, and that case is checked against the R1 formula and the overflow bound.

// File: rtl/trm_pkg.sv
package trm_pkg;

   typedef enum logic [0:0] {
      ADD_RIPPLE = 1'b0,
      ADD_PREFIX = 1'b1
   } adder_arch_e;

   // number of dropped low columns
   function automatic int drop_cols(input int n, input int k);
      return n - k;
   endfunction

   // width of the internal sum: one spare bit above the 2N-bit product
   function automatic int sum_width(input int n);
      return 2 * n + 1;
   endfunction

   // rows: N partial-product rows, T correction rows, one rounding row
   function automatic int row_count(input int n, input int k);
      return n + drop_cols(n, k) + 1;
   endfunction

endpackage

// File: rtl/trm_pp_matrix.sv
module trm_pp_matrix
   import trm_pkg::*;
#(
   parameter int N = 8,
   parameter int K = 3,
   localparam int T = drop_cols(N, K),
   localparam int W = sum_width(N),
   localparam int M = row_count(N, K)
) (
   input  logic [N-1:0]          a,
   input  logic [N-1:0]          b,
   output logic [M-1:0][W-1:0]   rows
);

   localparam int CORR_BASE  = N;
   localparam int ROUND_ROW  = N + T;
   localparam int CORR_COL   = T;
   localparam int ROUND_COL  = N - 1;

   // Row r (0..N-1) holds the kept AND terms of multiplier bit r.
   // Row N+r (0..T-1) holds the column-(T-1) term of bit r, lifted to column T.
   // The last row holds the rounding bit.
   always_comb begin
      rows = '0;
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            if (r + c >= T) begin
               rows[r][r + c] = a[c] & b[r];
            end else if (r + c == T - 1) begin
               rows[CORR_BASE + r][CORR_COL] = a[c] & b[r];
            end
         end
      end
      rows[ROUND_ROW][ROUND_COL] = 1'b1;
   end

endmodule

// File: rtl/trm_csa.sv
module trm_csa #(
   parameter int W = 17
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);

   logic [W-1:0] maj;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign s[i]   = x[i] ^ y[i] ^ z[i];
      assign maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
   end

   // carries move one column up; the top carry leaves the W-bit range
   assign c = {maj[W-2:0], 1'b0};

   logic unused_top_carry;
   assign unused_top_carry = maj[W-1];

endmodule

// File: rtl/trm_final_adder.sv
module trm_final_adder
   import trm_pkg::*;
#(
   parameter int          W    = 17,
   parameter adder_arch_e ARCH = ADD_PREFIX
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum
);

   if (ARCH == ADD_RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]    = x[i] ^ y[i] ^ cy[i];
         assign cy[i + 1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
      end
      logic unused_cout;
      assign unused_cout = cy[W];
   end else begin : g_prefix
      localparam int L = $clog2(W);
      logic [W-1:0] gl [L+1];
      logic [W-1:0] pl [L+1];

      assign gl[0] = x & y;
      assign pl[0] = x ^ y;

      for (genvar lv = 0; lv < L; lv++) begin : g_level
         localparam int D = 1 << lv;
         for (genvar i = 0; i < W; i++) begin : g_node
            if (i >= D) begin : g_merge
               assign gl[lv + 1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i - D]);
               assign pl[lv + 1][i] = pl[lv][i] & pl[lv][i - D];
            end else begin : g_pass
               assign gl[lv + 1][i] = gl[lv][i];
               assign pl[lv + 1][i] = pl[lv][i];
            end
         end
      end

      assign sum[0] = pl[0][0];
      for (genvar i = 1; i < W; i++) begin : g_sum
         assign sum[i] = pl[0][i] ^ gl[L][i - 1];
      end

      logic unused_prefix;
      assign unused_prefix = ^{pl[L], gl[L][W-1]};
   end

endmodule

// File: rtl/trunc_round_mul.sv
module trunc_round_mul
   import trm_pkg::*;
#(
   parameter int          N          = 8,
   parameter int          K          = 3,
   parameter adder_arch_e ADDER_ARCH = ADD_PREFIX,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   output logic [N-1:0] prod_hi
);

   localparam int W = sum_width(N);
   localparam int M = row_count(N, K);

   // elaboration-time parameter checks
   if (N < 2) begin : g_bad_width
      $error("trunc_round_mul: N must be at least 2");
   end
   if (K < 0 || K >= N) begin : g_bad_guard
      $error("trunc_round_mul: K must satisfy 0 <= K < N");
   end

   logic [M-1:0][W-1:0] rows;

   trm_pp_matrix #(
      .N (N),
      .K (K)
   ) u_matrix (
      .a    (op_a),
      .b    (op_b),
      .rows (rows)
   );

   // linear carry-save array: one 3:2 row per operand row after the first two
   logic [W-1:0] s_q [M-1];
   logic [W-1:0] c_q [M-1];

   assign s_q[0] = rows[0];
   assign c_q[0] = rows[1];

   for (genvar g = 1; g < M - 1; g++) begin : g_csa
      trm_csa #(
         .W (W)
      ) u_csa (
         .x (s_q[g - 1]),
         .y (c_q[g - 1]),
         .z (rows[g + 1]),
         .s (s_q[g]),
         .c (c_q[g])
      );
   end

   logic [W-1:0] s_fin;
   logic [W-1:0] c_fin;
   logic [W-1:0] sum_full;
   logic [N-1:0] rounded;

   assign s_fin = s_q[M - 2];
   assign c_fin = c_q[M - 2];

   trm_final_adder #(
      .W    (W),
      .ARCH (ADDER_ARCH)
   ) u_cpa (
      .x   (s_fin),
      .y   (c_fin),
      .sum (sum_full)
   );

   assign rounded = sum_full[2*N-1:N];

   logic unused_low;
   assign unused_low = ^sum_full[N-1:0];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            prod_hi <= '0;
         end else begin
            prod_hi <= rounded;
         end
      end

      // R5: a reset edge leaves a zero result behind
      p_reset_clear_r5: assert property (@(posedge clk)
         rst |=> (prod_hi == '0));

      // R4: a zero operand captured at an edge yields zero
      p_zero_operand_r4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && (($past(op_a) == '0) || ($past(op_b) == '0)))
            |-> (prod_hi == '0));
   end else begin : g_comb
      assign prod_hi = rounded;

      logic unused_clocking;
      assign unused_clocking = clk ^ rst;

      // R4: a zero operand gives zero in the same cycle
      p_zero_comb_r4: assert property (@(posedge clk) disable iff (rst)
         ((op_a == '0) || (op_b == '0)) |-> (prod_hi == '0));
   end

   // R2: the corrected sum never reaches bit 2N
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
      sum_full[W-1] == 1'b0);

   // R8: the chosen final adder resolves the carry-save pair exactly
   p_adder_exact_r8: assert property (@(posedge clk) disable iff (rst)
      sum_full == W'(s_fin + c_fin));

endmodule

// File: tb/trunc_round_mul_test.sv
module trunc_round_mul_test;
   import trm_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 6;
   localparam int KA = 2;
   localparam int NB = 4;
   localparam int KB = 0;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          rst;
   logic [NA-1:0] a_op_a, a_op_b, a_prod;
   logic [NB-1:0] b_op_a, b_op_b, b_prod;

   trunc_round_mul #(
      .N (NA), .K (KA), .ADDER_ARCH (ADD_PREFIX), .REG_OUT (1'b1)
   ) uut (
      .clk (clk), .rst (rst), .op_a (a_op_a), .op_b (a_op_b), .prod_hi (a_prod)
   );

   trunc_round_mul #(
      .N (NB), .K (KB), .ADDER_ARCH (ADD_RIPPLE), .REG_OUT (1'b0)
   ) uut_k0 (
      .clk (clk), .rst (rst), .op_a (b_op_a), .op_b (b_op_b), .prod_hi (b_prod)
   );

   typedef struct {
      int    exp_v;
      int    exact;
      bit    chk_err;
      string tag;
   } item_t;

   item_t sbq[$];
   int    checks   = 0;
   int    failures = 0;
   bit    done     = 1'b0;

   // model built from the R1 formula
   function automatic int model(input int a, input int b, input int n, input int k);
      int t = n - k;
      int s = 0;
      for (int r = 0; r < n; r++) begin
         for (int c = 0; c < n; c++) begin
            if (((a >> c) & 1) == 1 && ((b >> r) & 1) == 1) begin
               if (r + c >= t) s += (1 << (r + c));
               else if (r + c == t - 1) s += (1 << t);
            end
         end
      end
      s += (1 << (n - 1));
      return (s >> n) & ((1 << n) - 1);
   endfunction

   function automatic int exact_round(input int a, input int b, input int n);
      return (a * b + (1 << (n - 1))) >> n;
   endfunction

   task automatic check(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   // driver: apply operands at the falling edge and queue the expectation
   task automatic drive(input int a, input int b, input bit rv, input string tag);
      item_t it;
      @(negedge clk);
      rst    = rv;
      a_op_a = NA'(a);
      a_op_b = NA'(b);
      it.exp_v   = rv ? 0 : model(a, b, NA, KA);
      it.exact   = exact_round(a, b, NA);
      it.chk_err = !rv;
      it.tag     = tag;
      sbq.push_back(it);
   endtask

   // monitor: one queued item resolves at each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(it.tag, int'(a_prod), it.exp_v);
            if (it.chk_err) begin
               int diff;
               diff = int'(a_prod) - it.exact;
               checks++;
               if (diff < -1 || diff > 1) begin
                  failures++;
                  $display("FAIL R3 actual=%0d expected=%0d (+/-1)", a_prod, it.exact);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst    = 1'b1;
      a_op_a = '0;
      a_op_b = '0;
      b_op_a = '0;
      b_op_b = '0;

      // R5: reset wins over operands captured on the same edge
      drive(42, 21, 1'b1, "R5 reset state");
      drive(63, 63, 1'b1, "R5 reset with all-ones operands");
      drive(17, 50, 1'b1, "R5 reset with operands");

      // R1/R2/R4: exhaustive sweep of the registered instance
      for (int a = 0; a < (1 << NA); a++) begin
         for (int b = 0; b < (1 << NA); b++) begin
            if (a == 0 || b == 0)
               drive(a, b, 1'b0, "R4 zero operand");
            else if (a == 63 && b == 63)
               drive(a, b, 1'b0, "R2 all-ones corner");
            else
               drive(a, b, 1'b0, "R1 corrected result");
         end
      end

      // R5: reset in mid-stream, then the first pair after release
      drive(63, 63, 1'b1, "R5 mid-stream reset");
      drive(37, 45, 1'b0, "R5 first capture after reset");
      drive(63, 1, 1'b0, "R1 single-bit multiplier");

      repeat (3) @(posedge clk);
      #2;

      // R6/R7/R8: combinational ripple instance with K = 0
      for (int a = 0; a < (1 << NB); a++) begin
         for (int b = 0; b < (1 << NB); b++) begin
            @(negedge clk);
            b_op_a = NB'(a);
            b_op_b = NB'(b);
            #1;
            if (a == 15 && b == 15)
               check("R8 ripple adder all ones", int'(b_prod), model(a, b, NB, KB));
            else if (a == 9)
               check("R6 same-cycle result", int'(b_prod), model(a, b, NB, KB));
            else if (a == 0 || b == 0)
               check("R4 zero operand comb", int'(b_prod), 0);
            else
               check("R7 K=0 correction", int'(b_prod), model(a, b, NB, KB));
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule